// File: doc/BRIEF.md
# Two-Checksum Command Packet Parser

This block takes in a stream of bytes from a serial receiver and breaks it into command packets. Every packet begins with a header of the same fixed length. The header carries an operation code, the identifier of the target unit, a channel index and a 16-bit count of payload bytes. A 16-bit checksum over those header bytes follows it. When the count is not zero, that many payload bytes come next, followed by a second 16-bit checksum that covers only the payload. Payloads hold settings such as channel and trigger configuration. They go to a downstream consumer as a plain byte stream.

Neither checksum is used to repair data. When a check fails, the packet is closed with a bad status and a retransmission request is raised for one cycle. No part of the packet reaches the outputs. To make this possible, payload bytes are held in an internal store until their checksum has been confirmed. Only then are they released back to back. Header fields are published only when the header checksum matches. A header that fails its check, or that announces more payload than the store can hold, is abandoned. The parser then treats the very next byte as the start of a new header.

Top module: `cmd_pkt_parser`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1 and `pl_valid`, `pkt_done`, `retx_req` and `hdr_ok` are all 0.
- R2: Header bytes arrive in this order: opcode, unit id, channel, length high byte, length low byte. The header checksum follows, high byte first. If the checksum matches and the length is at most `MAX_PAYLOAD`, then one cycle after the last checksum byte is accepted, `hdr_ok` pulses. From that cycle on, `cmd_code`, `dev_id`, `chan_num` and `pay_len` show the fields, and they hold until the next good header.
- R3: Both checksums use the polynomial x^16+x^12+x^5+1 (0x1021), start from 0xFFFF and take each byte most significant bit first. The payload checksum restarts from 0xFFFF at the first payload byte and covers only payload bytes.
- R4: For a good header with length 0, `pkt_done` is 1 with `pkt_good` 1 and `retx_req` 0 one cycle after the last header checksum byte. The next accepted byte is taken as a new opcode.
- R5: If the header checksum does not match, `pkt_done` is 1 with `pkt_good` 0 and `retx_req` 1 one cycle after the last checksum byte. `hdr_ok` stays 0, the published fields keep their earlier values, and the next accepted byte starts a new header whatever the length said.
- R6: If the payload checksum matches, the payload bytes appear on `pl_data` with `pl_valid` 1 in consecutive cycles, in arrival order. The first appears one cycle after the last payload checksum byte. `pl_last` marks the final byte, `in_ready` is 0 during the release, and `pkt_done` with `pkt_good` 1 follows in the cycle after the final byte.
- R7: If the payload checksum does not match, no payload byte is ever shown on `pl_valid`. `pkt_done` is 1 with `pkt_good` 0 and `retx_req` 1 one cycle after the last payload checksum byte.
- R8: A header with a matching checksum whose length exceeds `MAX_PAYLOAD` is closed like a failed header, as in R5, and no payload is expected after it.
- R9: `pkt_done` and `retx_req` are single-cycle pulses, and `retx_req` is only ever 1 together with `pkt_done` 1 and `pkt_good` 0.
- R10: Cycles with `in_valid` 0 consume nothing. A packet whose bytes are separated by idle cycles is parsed exactly as a gap-free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Parser accepts the offered byte this cycle |
| hdr_ok | output | 1 | One-cycle pulse: a checked header has been published |
| cmd_code | output | 8 | Opcode of the last good header |
| dev_id | output | 8 | Unit identifier of the last good header |
| chan_num | output | 8 | Channel index of the last good header |
| pay_len | output | 16 | Payload length of the last good header |
| pl_valid | output | 1 | Released payload byte on `pl_data` |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final byte of the released payload |
| pkt_done | output | 1 | One-cycle pulse: packet finished |
| pkt_good | output | 1 | With `pkt_done`: 1 good, 0 defective |
| retx_req | output | 1 | One-cycle pulse asking the sender to repeat the packet |

## Verification
The assertions rely on the sender keeping to the framing: after a header that fails its check or announces too much payload, it sends no payload and starts a fresh header. The assertions also assume the downstream side takes every released byte without back-pressure. The stimulus keeps to this by building each packet whole in the bench, sending only header bytes for packets that are meant to be rejected at the header, and never offering a byte while `in_ready` is 0. Random idle gaps between bytes and random corruption of one checksum or payload bit change the packets without breaking the framing.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;

  localparam int BYTE_W    = 8;
  localparam int LEN_W     = 16;
  localparam int CRC_W     = 16;
  localparam int HDR_BYTES = 5;
  localparam int CHK_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    PS_HDR,
    PS_HCRC,
    PS_PL,
    PS_PCRC,
    PS_DRAIN
  } parse_st_e;

  // One byte of the 0x1021 checksum, folded so that a whole byte is absorbed
  // with shifts and XORs instead of eight single-bit steps.
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] x;
    x = {8'h00, cur[15:8] ^ d};
    x = x ^ (x >> 4);
    return (cur << 8) ^ (x << 12) ^ (x << 5) ^ x;
  endfunction

endpackage

// File: rtl/cmd_pkt_crc.sv
module cmd_pkt_crc
  import cmd_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= CRC_SEED;
    else if (clr) crc_q <= CRC_SEED;
    else if (en)  crc_q <= crc16_byte(crc_q, din);
  end

  assign crc = crc_q;

  // Restart and absorb are never requested together by the parser.
  AST_CRC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && en)); // R3

endmodule

// File: rtl/cmd_pkt_store.sv
module cmd_pkt_store
  import cmd_pkt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH)); // R6

endmodule

// File: rtl/cmd_pkt_parser.sv
module cmd_pkt_parser
  import cmd_pkt_pkg::*;
#(
  parameter int MAX_PAYLOAD = 64
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        hdr_ok,
  output logic [7:0]  cmd_code,
  output logic [7:0]  dev_id,
  output logic [7:0]  chan_num,
  output logic [15:0] pay_len,
  output logic        pl_valid,
  output logic [7:0]  pl_data,
  output logic        pl_last,
  output logic        pkt_done,
  output logic        pkt_good,
  output logic        retx_req
);

  localparam int AW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PAYLOAD);
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] CHK_LAST = LEN_W'(CHK_BYTES - 1);

  parse_st_e         st_q, st_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] chk_hi_q;
  logic [BYTE_W-1:0] sh_cmd_q, sh_dev_q, sh_chan_q;
  logic [LEN_W-1:0]  sh_len_q;
  logic [CRC_W-1:0]  crc_val;
  logic              done_q, good_q, retx_q, hdr_ok_q;

  // Named events, used by both the sequencing and the assertions.
  logic acc, crc_match, len_fits;
  logic ev_hcrc_end, ev_hdr_good, ev_hdr_bad;
  logic ev_pl_last, ev_pcrc_end, ev_pl_good, ev_pl_bad;
  logic ev_drain_end, ev_done_good, ev_done_bad;
  logic crc_clr, crc_en, store_we;

  assign in_ready = (st_q != PS_DRAIN);
  assign acc      = in_valid && in_ready;

  assign crc_match    = ({chk_hi_q, in_data} == crc_val);
  assign len_fits     = (sh_len_q <= LEN_MAX);
  assign ev_hcrc_end  = acc && (st_q == PS_HCRC) && (cnt_q == CHK_LAST);
  assign ev_hdr_good  = ev_hcrc_end && crc_match && len_fits;
  assign ev_hdr_bad   = ev_hcrc_end && !(crc_match && len_fits);
  assign ev_pl_last   = acc && (st_q == PS_PL) && (cnt_q == sh_len_q - 1'b1);
  assign ev_pcrc_end  = acc && (st_q == PS_PCRC) && (cnt_q == CHK_LAST);
  assign ev_pl_good   = ev_pcrc_end && crc_match;
  assign ev_pl_bad    = ev_pcrc_end && !crc_match;
  assign ev_drain_end = (st_q == PS_DRAIN) && (cnt_q == sh_len_q - 1'b1);
  assign ev_done_good = (ev_hdr_good && (sh_len_q == '0)) || ev_drain_end;
  assign ev_done_bad  = ev_hdr_bad || ev_pl_bad;

  // Sequencing
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PS_HDR: if (acc) begin
        if (cnt_q == HDR_LAST) begin st_d = PS_HCRC; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      PS_HCRC: if (acc) begin
        if (cnt_q != CHK_LAST) cnt_d = cnt_q + 1'b1;
        else begin
          cnt_d = '0;
          st_d  = (ev_hdr_good && (sh_len_q != '0)) ? PS_PL : PS_HDR;
        end
      end
      PS_PL: if (acc) begin
        if (ev_pl_last) begin st_d = PS_PCRC; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      PS_PCRC: if (acc) begin
        if (cnt_q != CHK_LAST) cnt_d = cnt_q + 1'b1;
        else begin
          cnt_d = '0;
          st_d  = ev_pl_good ? PS_DRAIN : PS_HDR;
        end
      end
      PS_DRAIN: begin
        if (ev_drain_end) begin st_d = PS_HDR; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: begin st_d = PS_HDR; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PS_HDR;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Header field shadows and checksum high byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cmd_q  <= '0;
      sh_dev_q  <= '0;
      sh_chan_q <= '0;
      sh_len_q  <= '0;
      chk_hi_q  <= '0;
    end else if (acc) begin
      if (st_q == PS_HDR) begin
        unique case (cnt_q[2:0])
          3'd0:    sh_cmd_q  <= in_data;
          3'd1:    sh_dev_q  <= in_data;
          3'd2:    sh_chan_q <= in_data;
          3'd3:    sh_len_q[15:8] <= in_data;
          default: sh_len_q[7:0]  <= in_data;
        endcase
      end
      if (((st_q == PS_HCRC) || (st_q == PS_PCRC)) && (cnt_q == '0))
        chk_hi_q <= in_data;
    end
  end

  // Published fields and status pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code <= '0;
      dev_id   <= '0;
      chan_num <= '0;
      pay_len  <= '0;
      hdr_ok_q <= 1'b0;
      done_q   <= 1'b0;
      good_q   <= 1'b0;
      retx_q   <= 1'b0;
    end else begin
      hdr_ok_q <= ev_hdr_good;
      done_q   <= ev_done_good || ev_done_bad;
      good_q   <= ev_done_good;
      retx_q   <= ev_done_bad;
      if (ev_hdr_good) begin
        cmd_code <= sh_cmd_q;
        dev_id   <= sh_dev_q;
        chan_num <= sh_chan_q;
        pay_len  <= sh_len_q;
      end
    end
  end

  assign hdr_ok   = hdr_ok_q;
  assign pkt_done = done_q;
  assign pkt_good = good_q;
  assign retx_req = retx_q;

  // Checksum engine: restarts whenever a new header or payload begins
  assign crc_clr = ((st_q != PS_HDR) && (st_d == PS_HDR)) ||
                   ((st_q == PS_HCRC) && (st_d == PS_PL));
  assign crc_en  = acc && ((st_q == PS_HDR) || (st_q == PS_PL));

  cmd_pkt_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc_val)
  );

  // Payload store: written while receiving, read while releasing
  assign store_we = acc && (st_q == PS_PL);

  cmd_pkt_store #(.DEPTH(MAX_PAYLOAD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_we),
    .wr_addr (cnt_q[AW-1:0]),
    .wr_data (in_data),
    .rd_addr (cnt_q[AW-1:0]),
    .rd_data (pl_data)
  );

  assign pl_valid = (st_q == PS_DRAIN);
  assign pl_last  = ev_drain_end;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R9
  AST_RETX_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> (pkt_done && !pkt_good)); // R9
  AST_RELEASE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    pl_last |=> (pkt_done && pkt_good)); // R6
  AST_RELEASE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_last) |=> pl_valid); // R6
  AST_HDR_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |-> (pay_len <= LEN_MAX)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(cnt_q) && $stable(st_q))); // R10
  AST_BAD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pl_bad |=> !pl_valid); // R7

endmodule

// File: tb/tb_cmd_pkt_parser.sv
`timescale 1ns/1ps
module tb_cmd_pkt_parser;

  localparam int MAXP = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready, hdr_ok, pl_valid, pl_last, pkt_done, pkt_good, retx_req;
  logic [7:0]  cmd_code, dev_id, chan_num, pl_data;
  logic [15:0] pay_len;

  int nvec = 0, nbad = 0;
  int gap_max = 0;
  int pl_seen = 0, pl_exp = 0;
  bit finished = 0;
  logic [7:0]  last_cmd = 0, last_dev = 0, last_chan = 0;
  logic [15:0] last_len = 0;

  always #2 clk = ~clk;

  cmd_pkt_parser #(.MAX_PAYLOAD(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .hdr_ok(hdr_ok), .cmd_code(cmd_code), .dev_id(dev_id),
    .chan_num(chan_num), .pay_len(pay_len), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_last(pl_last), .pkt_done(pkt_done), .pkt_good(pkt_good), .retx_req(retx_req)
  );

  always @(negedge clk) if (rst_n === 1'b1 && pl_valid === 1'b1) pl_seen++;

  // Bit-serial restatement of the checksum
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int b = 7; b >= 0; b--) begin
      fb = c[15] ^ d[b];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the byte is accepted.
  task automatic send_byte(input logic [7:0] b);
    int g;
    g = (gap_max > 0) ? $urandom_range(0, gap_max) : 0;
    repeat (g) @(negedge clk);
    while (in_ready !== 1'b1) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom_range(0, 255);
  endtask

  // kind: 0 good, 1 bad header checksum, 2 bad payload, 3 oversize length
  task automatic run_pkt(input int kind, input logic [7:0] c, input logic [7:0] d,
                         input logic [7:0] ch, input int plen);
    logic [7:0]  hdr [5];
    logic [7:0]  pay [$];
    logic [15:0] hc, pc;
    int k;
    k = kind;
    if (k == 2 && plen == 0) k = 0;
    hdr[0] = c; hdr[1] = d; hdr[2] = ch; hdr[3] = plen[15:8]; hdr[4] = plen[7:0];
    hc = 16'hFFFF;
    for (int i = 0; i < 5; i++) hc = ref_crc(hc, hdr[i]);
    if (k == 1) hc = hc ^ (16'h1 << $urandom_range(0, 15));
    for (int i = 0; i < 5; i++) send_byte(hdr[i]);
    send_byte(hc[15:8]);
    send_byte(hc[7:0]);
    if (k == 1 || k == 3) begin
      chk(k == 1 ? "R5 done" : "R8 done", pkt_done, 1);
      chk(k == 1 ? "R5 good" : "R8 good", pkt_good, 0);
      chk(k == 1 ? "R5 retx" : "R8 retx", retx_req, 1);
      chk(k == 1 ? "R5 hdr_ok" : "R8 hdr_ok", hdr_ok, 0);
      chk("R5 fields kept", {cmd_code, dev_id, chan_num, pay_len},
          {last_cmd, last_dev, last_chan, last_len});
      return;
    end
    chk("R2 hdr_ok", hdr_ok, 1);
    chk("R2 fields", {cmd_code, dev_id, chan_num, pay_len}, {c, d, ch, plen[15:0]});
    last_cmd = c; last_dev = d; last_chan = ch; last_len = plen[15:0];
    if (plen == 0) begin
      chk("R4 done", pkt_done, 1);
      chk("R4 good", pkt_good, 1);
      chk("R4 retx", retx_req, 0);
      return;
    end
    chk("R6 no early done", pkt_done, 0);
    pc = 16'hFFFF;
    for (int i = 0; i < plen; i++) begin
      pay.push_back($urandom_range(0, 255));
      pc = ref_crc(pc, pay[i]);
    end
    if (k == 2) begin
      if ($urandom_range(0, 1) == 1) pay[$urandom_range(0, plen - 1)] ^= 8'h01 << $urandom_range(0, 7);
      else pc = pc ^ (16'h1 << $urandom_range(0, 15));
    end
    for (int i = 0; i < plen; i++) send_byte(pay[i]);
    send_byte(pc[15:8]);
    send_byte(pc[7:0]);
    if (k == 2) begin
      chk("R7 done", pkt_done, 1);
      chk("R7 good", pkt_good, 0);
      chk("R7 retx", retx_req, 1);
      chk("R7 no release", pl_valid, 0);
      return;
    end
    pl_exp += plen;
    for (int i = 0; i < plen; i++) begin
      chk("R6 valid", pl_valid, 1);
      chk("R6 data", pl_data, pay[i]);
      chk("R6 last", pl_last, (i == plen - 1));
      chk("R6 stall", in_ready, 0);
      if (i == 0) chk("R3 payload restart", pkt_done, 0);
      @(negedge clk);
    end
    chk("R6 done", pkt_done, 1);
    chk("R6 good", pkt_good, 1);
    chk("R9 retx quiet", retx_req, 0);
    chk("R6 release over", pl_valid, 0);
  endtask

  initial begin
    logic [15:0] kc;
    byte unsigned ks [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", in_ready, 1);
    chk("R1 quiet", {pl_valid, pkt_done, retx_req, hdr_ok}, 0);

    kc = 16'hFFFF;
    foreach (ks[i]) kc = ref_crc(kc, ks[i]);
    chk("R3 check value", kc, 16'h29B1);

    // Directed corner cases
    run_pkt(0, 8'h11, 8'h22, 8'h33, 0);          // R4 header only
    run_pkt(1, 8'h44, 8'h55, 8'h66, 0);          // R5
    run_pkt(1, 8'h47, 8'h58, 8'h69, 20);         // R5 resync despite length
    run_pkt(0, 8'h01, 8'h02, 8'h03, 1);          // R6 single byte
    run_pkt(0, 8'hA0, 8'hB0, 8'hC0, MAXP);       // R6 full store
    run_pkt(3, 8'h0F, 8'h0E, 8'h0D, MAXP + 1);   // R8 just over
    run_pkt(3, 8'h0C, 8'h0B, 8'h0A, 16'hFFFF);   // R8 far over
    run_pkt(2, 8'h70, 8'h71, 8'h72, 9);          // R7
    gap_max = 4;                                 // R10 idle gaps
    run_pkt(0, 8'h5A, 8'hA5, 8'h3C, 12);
    run_pkt(0, 8'hC3, 8'h96, 8'h69, 0);

    // Constrained random packets
    gap_max = 2;
    for (int n = 0; n < 120; n++) begin
      int r, kind, plen;
      r = $urandom_range(0, 9);
      kind = (r <= 5) ? 0 : (r == 6) ? 1 : (r <= 8) ? 2 : 3;
      if (kind == 3) plen = $urandom_range(MAXP + 1, 65535);
      else if ($urandom_range(0, 3) == 0) plen = 0;
      else plen = $urandom_range(1, MAXP);
      if (n % 5 == 0) gap_max = 0; else gap_max = 2;
      run_pkt(kind, $urandom_range(0, 255), $urandom_range(0, 255),
              $urandom_range(0, 255), plen);
    end

    repeat (3) @(negedge clk);
    chk("R7 released byte total", pl_seen, pl_exp);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule